// File: doc/BRIEF.md
# Double-Width Sequential Integer Divider

This block divides a 2W-bit dividend by a W-bit divisor one quotient bit per clock. It uses a restoring shift-subtract loop that works on operand magnitudes. It returns a W-bit quotient and a W-bit remainder packed into one 2W-bit result word. The operands can be treated as unsigned or as two's-complement numbers. A zero divisor, or a quotient that does not fit in W bits, produces an error flag in place of a result.

Two extra unsigned modes are available. The rounding mode raises the quotient by one when the remainder is at least half the divisor. The fraction mode runs a second pass of the loop. That pass turns the remainder into a W-bit binary fraction of the divisor.

Requests enter through a valid/ready handshake. Results leave through a second valid/ready handshake. Only one request is in flight at a time. The result stays on the outputs until the consumer accepts it.

Top module: `wide_divider`

## Requirements
- R1: In unsigned truncating operation, result bits [W-1:0] hold the quotient and bits [2W-1:W] hold the remainder. The dividend equals quotient times divisor plus remainder, and the remainder is smaller than the divisor.
- R2: A zero divisor raises out_err in every mode and with either signedness. The result word is then all zeros.
- R3: An unsigned quotient of 2^W or more raises out_err with an all-zero result word. For example, 0x00030000 / 2 fails, while 0xFFFEFFFF / 0xFFFF gives quotient 0xFFFF and remainder 0xFFFE.
- R4: When in_signed is 1 and in_mode is 0 or 3, the operands are two's complement. The quotient truncates toward zero and a nonzero remainder takes the dividend's sign. Examples: -100/9 gives -11 rem -1; 16/-3 gives -5 rem 1; -16/3 gives -5 rem -1.
- R5: A signed quotient is an overflow error when it exceeds 2^(W-1)-1 for a positive result, or is below -2^(W-1) for a negative result. For example, 32768/1 fails and -32768/1 gives 0x8000.
- R6: With in_mode 1 (rounding), the operands are unsigned whatever in_signed says. The quotient is incremented when twice the remainder is at least the divisor. The remainder field still holds the unrounded remainder.
- R7: In rounding mode, if rounding would carry the quotient up to 2^W, out_err is raised with an all-zero result word.
- R8: With in_mode 2 (fraction), the operands are unsigned. Bits [W-1:0] hold the integer quotient. Bits [2W-1:W] hold floor(remainder * 2^W / divisor), a binary fraction whose point sits just above its MSB. For example, 13/2 gives 6 and 0x8000.
- R9: out_valid first goes high W+2 cycles after the cycle in which a request is accepted. In fraction mode this is 2W+3 cycles. The latency is the same whether or not the request ends in an error.
- R10: in_ready is high only while no request is in progress. After reset, in_ready is 1 and out_valid is 0. out_result and out_err hold steady while out_valid is high and out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Divider idle, request will be taken |
| in_dividend | input | 2W | Dividend |
| in_divisor | input | W | Divisor |
| in_signed | input | 1 | Two's-complement operands (truncating modes only) |
| in_mode | input | 2 | 0/3 truncate, 1 round, 2 fraction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 2W | {remainder or fraction, quotient}; zero on error |
| out_err | output | 1 | Divide error (zero divisor or overflow) |

## Verification
The in-line assertions check the handshake rules on every cycle: idle and busy never overlap, a stalled result does not move, a zero divisor always reports an error, and an error always clears the result word. They also check that an unsigned truncating remainder stays below the divisor. Only the bench scenarios can show that the arithmetic values are right. That covers the signed sign rules, the overflow boundaries on both sides of 2^(W-1), the rounding carry, the fraction bits and the exact latency of each mode. The bench compares every output against an independent integer model under random backpressure.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  typedef enum logic [1:0] {
    OP_TRUNC     = 2'd0,
    OP_ROUND     = 2'd1,
    OP_FRAC      = 2'd2,
    OP_TRUNC_ALT = 2'd3
  } op_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_SEED,
    ST_FRAC,
    ST_FIX,
    ST_DONE
  } div_state_e;
endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           is_signed,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           neg_quot,
  output logic           neg_rem,
  output logic           div_zero,
  output logic           pre_ovf
);
  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg  = is_signed & dividend[2*W-1];
    dvs_neg  = is_signed & divisor[W-1];
    dvd_mag  = dvd_neg ? -dividend : dividend;
    dvs_mag  = dvs_neg ? -divisor : divisor;
    neg_quot = dvd_neg ^ dvs_neg;
    neg_rem  = dvd_neg;
    div_zero = (divisor == '0);
    // High half not below divisor means the magnitude quotient needs W+1 bits
    pre_ovf  = (dvd_mag[2*W-1:W] >= dvs_mag);
  end
endmodule

// File: rtl/wdiv_step.sv
module wdiv_step #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] acc_in,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] acc_out
);
  logic [W:0]   trial;
  logic [W-1:0] diff;

  always_comb begin
    trial = acc_in[2*W-1:W-1];
    diff  = trial[W-1:0] - dvs;
    if (trial >= {1'b0, dvs})
      acc_out = {diff, acc_in[W-2:0], 1'b1};
    else
      acc_out = {acc_in[2*W-2:0], 1'b0};
  end
endmodule

// File: rtl/wdiv_finish.sv
module wdiv_finish
  import wdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   int_quot,
  input  logic [W-1:0]   dvs_mag,
  input  op_mode_e       mode,
  input  logic           is_signed,
  input  logic           neg_quot,
  input  logic           neg_rem,
  input  logic           div_zero,
  input  logic           pre_ovf,
  output logic           err,
  output logic [2*W-1:0] result
);
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q_mag, r_mag, lo, hi;
  logic         round_up, range_err;

  always_comb begin
    q_mag     = acc[W-1:0];
    r_mag     = acc[2*W-1:W];
    round_up  = ({r_mag, 1'b0} >= {1'b0, dvs_mag});
    lo        = q_mag;
    hi        = r_mag;
    range_err = 1'b0;
    case (mode)
      OP_ROUND: begin
        lo        = q_mag + {{(W-1){1'b0}}, round_up};
        range_err = round_up & (&q_mag);
      end
      OP_FRAC: begin
        lo = int_quot;
        hi = q_mag;
      end
      default: begin
        if (is_signed) begin
          lo        = neg_quot ? -q_mag : q_mag;
          hi        = neg_rem ? -r_mag : r_mag;
          range_err = neg_quot ? (q_mag > NEG_LIMIT) : q_mag[W-1];
        end
      end
    endcase
    err    = div_zero | pre_ovf | range_err;
    result = err ? '0 : {hi, lo};
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2*W-1:0] in_dividend,
  input  logic [W-1:0]   in_divisor,
  input  logic           in_signed,
  input  logic [1:0]     in_mode,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_result,
  output logic           out_err
);
  localparam int            CW   = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e     state;
  logic [CW-1:0]  cnt;
  logic [2*W-1:0] acc;
  logic [W-1:0]   dvs_q, int_q;
  op_mode_e       mode_q;
  logic           sgn_q, negq_q, negr_q, zero_q, povf_q;

  op_mode_e       req_mode;
  logic           eff_signed;
  logic [2*W-1:0] p_dvd;
  logic [W-1:0]   p_dvs;
  logic           p_negq, p_negr, p_zero, p_povf;
  logic [2*W-1:0] step_acc;
  logic           fin_err;
  logic [2*W-1:0] fin_result;

  assign req_mode   = op_mode_e'(in_mode);
  assign eff_signed = in_signed & ((req_mode == OP_TRUNC) | (req_mode == OP_TRUNC_ALT));
  assign in_ready   = (state == ST_IDLE);

  wdiv_prep #(.W(W)) u_prep (
    .dividend (in_dividend),
    .divisor  (in_divisor),
    .is_signed(eff_signed),
    .dvd_mag  (p_dvd),
    .dvs_mag  (p_dvs),
    .neg_quot (p_negq),
    .neg_rem  (p_negr),
    .div_zero (p_zero),
    .pre_ovf  (p_povf)
  );

  wdiv_step #(.W(W)) u_step (
    .acc_in (acc),
    .dvs    (dvs_q),
    .acc_out(step_acc)
  );

  wdiv_finish #(.W(W)) u_finish (
    .acc      (acc),
    .int_quot (int_q),
    .dvs_mag  (dvs_q),
    .mode     (mode_q),
    .is_signed(sgn_q),
    .neg_quot (negq_q),
    .neg_rem  (negr_q),
    .div_zero (zero_q),
    .pre_ovf  (povf_q),
    .err      (fin_err),
    .result   (fin_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      acc        <= '0;
      dvs_q      <= '0;
      int_q      <= '0;
      mode_q     <= OP_TRUNC;
      sgn_q      <= 1'b0;
      negq_q     <= 1'b0;
      negr_q     <= 1'b0;
      zero_q     <= 1'b0;
      povf_q     <= 1'b0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_err    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          acc    <= p_dvd;
          dvs_q  <= p_dvs;
          mode_q <= req_mode;
          sgn_q  <= eff_signed;
          negq_q <= p_negq;
          negr_q <= p_negr;
          zero_q <= p_zero;
          povf_q <= p_povf;
          cnt    <= '0;
          state  <= ST_INT;
        end
        ST_INT: begin
          acc <= step_acc;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= (mode_q == OP_FRAC) ? ST_SEED : ST_FIX;
        end
        ST_SEED: begin
          int_q <= acc[W-1:0];
          acc   <= {acc[2*W-1:W], {W{1'b0}}};
          cnt   <= '0;
          state <= ST_FRAC;
        end
        ST_FRAC: begin
          acc <= step_acc;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          out_result <= fin_result;
          out_err    <= fin_err;
          out_valid  <= 1'b1;
          state      <= ST_DONE;
        end
        ST_DONE: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: never idle while a result is waiting
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R10: stalled result holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_err));

  // R2: zero divisor always reported
  a_r2_zero_err: assert property (@(posedge clk) disable iff (rst)
    out_valid && zero_q |-> out_err);

  // R3: error result word is cleared
  a_r3_err_clear: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_result == '0);

  // R1: unsigned truncating remainder below divisor
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_err && !sgn_q && (mode_q == OP_TRUNC) |-> out_result[2*W-1:W] < dvs_q);
endmodule

// File: tb/wide_divider_tb.sv
module wide_divider_tb;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic           err;
    logic [2*W-1:0] res;
    longint         acc_cyc;
    int             lat;
    logic           timed;
    string          tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_signed = 1'b0, out_valid, out_ready = 1'b1, out_err;
  logic [2*W-1:0] in_dividend = '0, out_result;
  logic [W-1:0] in_divisor = '0;
  logic [1:0] in_mode = 2'd0;
  logic bp_on = 1'b0;

  longint cyc = 0;
  int checks = 0, fails = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wide_divider #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_signed(in_signed),
    .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_err(out_err)
  );

  function automatic void model(input logic [2*W-1:0] dvd, input logic [W-1:0] dvs,
                                input logic sgn, input logic [1:0] md,
                                output logic err, output logic [2*W-1:0] res, output int lat);
    longint a, b, q, r, f, lim;
    lim = longint'(1) << W;
    lat = (md == 2'd2) ? 2*W + 3 : W + 2;
    err = 1'b0;
    res = '0;
    if (dvs == '0) begin err = 1'b1; return; end
    if (sgn && (md == 2'd0 || md == 2'd3)) begin
      a = longint'($signed(dvd));
      b = longint'($signed(dvs));
      q = a / b;
      r = a % b;
      if (q > lim/2 - 1 || q < -(lim/2)) err = 1'b1;
      else res = {r[W-1:0], q[W-1:0]};
    end else begin
      a = longint'(dvd);
      b = longint'(dvs);
      q = a / b;
      r = a % b;
      if (q >= lim) begin err = 1'b1; return; end
      if (md == 2'd1) begin
        if (2*r >= b) q = q + 1;
        if (q >= lim) err = 1'b1;
        else res = {r[W-1:0], q[W-1:0]};
      end else if (md == 2'd2) begin
        f = (r << W) / b;
        res = {f[W-1:0], q[W-1:0]};
      end else res = {r[W-1:0], q[W-1:0]};
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [2*W-1:0] dvd, input logic [W-1:0] dvs,
                      input logic sgn, input logic [1:0] md, input string tag);
    exp_t e;
    model(dvd, dvs, sgn, md, e.err, e.res, e.lat);
    e.tag = tag;
    e.timed = 1'b0;
    @(negedge clk);
    in_dividend = dvd; in_divisor = dvs; in_signed = sgn; in_mode = md; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e.acc_cyc = cyc;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: latency on first appearance, value on handshake
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) check(1'b0, "R10", "unexpected result", 0, 0);
      else begin
        if (!sb[0].timed) begin
          check(cyc - sb[0].acc_cyc == sb[0].lat, "R9", {sb[0].tag, " latency"},
                cyc - sb[0].acc_cyc, sb[0].lat);
          sb[0].timed = 1'b1;
        end
        if (out_ready) begin
          check(out_err === sb[0].err && out_result === sb[0].res, sb[0].tag, "err/result",
                longint'({out_err, out_result}), longint'({sb[0].err, sb[0].res}));
          void'(sb.pop_front());
        end
      end
    end
  end

  // Consumer backpressure
  initial forever begin
    @(posedge clk);
    out_ready <= bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R10", "reset state",
          longint'({in_ready, out_valid}), 2);

    // R1 unsigned truncation
    send(32'd50, 16'd5, 1'b0, 2'd0, "R1");
    @(negedge clk);
    check(in_ready === 1'b0, "R10", "busy ready", in_ready, 0);
    send(32'h1234_5678, 16'hABCD, 1'b0, 2'd0, "R1");
    send(32'hFFFE_FFFF, 16'hFFFF, 1'b0, 2'd0, "R3");
    // R2 zero divisor
    send(32'h0000_1234, 16'd0, 1'b0, 2'd0, "R2");
    send(32'hFFFF_FF9C, 16'd0, 1'b1, 2'd0, "R2");
    send(32'd13, 16'd0, 1'b0, 2'd2, "R2");
    // R3 unsigned overflow
    send(32'h0003_0000, 16'd2, 1'b0, 2'd0, "R3");
    send(32'hFFFF_FFFF, 16'hFFFF, 1'b0, 2'd0, "R3");
    // R4 signed rules
    send(32'hFFFF_FF9C, 16'd9, 1'b1, 2'd0, "R4");
    send(32'd16, 16'hFFFD, 1'b1, 2'd0, "R4");
    send(32'hFFFF_FFF0, 16'd3, 1'b1, 2'd3, "R4");
    // R5 signed range edges
    send(32'd32768, 16'd1, 1'b1, 2'd0, "R5");
    send(32'hFFFF_8000, 16'd1, 1'b1, 2'd0, "R5");
    send(32'd32767, 16'd1, 1'b1, 2'd0, "R5");
    send(32'h8000_0000, 16'hFFFF, 1'b1, 2'd0, "R5");
    // R6 rounding
    send(32'd13, 16'd2, 1'b0, 2'd1, "R6");
    send(32'd14, 16'd4, 1'b0, 2'd1, "R6");
    send(32'd13, 16'd4, 1'b0, 2'd1, "R6");
    send(32'h0001_0003, 16'hFFFF, 1'b1, 2'd1, "R6");
    // R7 rounding carry-out
    send(32'h0001_FFFF, 16'd2, 1'b0, 2'd1, "R7");
    // R8 fraction
    send(32'd13, 16'd2, 1'b0, 2'd2, "R8");
    send(32'd1, 16'd3, 1'b1, 2'd2, "R8");

    bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] d, hi;
      logic [1:0] m;
      d  = W'($urandom);
      m  = 2'($urandom);
      hi = (d != 0 && ($urandom % 4) != 0) ? W'($urandom % d) : W'($urandom);
      send({hi, W'($urandom)}, d, 1'($urandom), m,
           (m == 2'd1) ? "R6" : (m == 2'd2) ? "R8" : "R1");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule